// File: doc/BRIEF.md
# Shared Device Control Register Block

This block holds the registers shared by the four serial channels of a multi-channel serial controller. It sits in a 32-bit target address space and occupies five consecutive 32-bit words starting at byte offset 0x080. A bus front end, which is not part of this block, turns each bus cycle into a single-cycle request. The request carries a word address, four byte enables and write data. Read data returns one clock later.

The block collects the interrupt line of each channel into one global status byte. It drives a single combined interrupt output that also follows a separate I/O interrupt input. It issues one-cycle soft-reset pulses to individual channels through a write-only byte that never holds a value. It keeps per-channel sleep enables, a clock-mode byte, a timer control byte and a 16-bit timer preload word, each of which it presents on ports to the logic that uses it. It also returns a fixed revision byte and a fixed identification byte. Every writable byte lane is written only when its byte enable is set, so a single double-word write can update several registers in the same cycle.

Top module: `devctl_regs`

## Requirements
- R1: After reset the sleep, clock-mode, timer-control and timer-preload outputs are zero, no reset pulse is driven, and every writable byte reads back as zero.
- R2: A read of word 0x080 returns the channel interrupt inputs, as sampled in the request cycle, in bits [3:0] (bit n is channel n). All other bits of that word read as zero, including reserved byte 0x083. Writes to this word have no effect.
- R3: The combined interrupt output is high one cycle after any channel interrupt input or the I/O interrupt input is high, and low one cycle after all of them are low.
- R4: A write to word 0x088 with byte enable 2 set produces a pulse on the channel reset outputs. The pulse pattern is write-data bits [19:16], where bit 16 is channel 0. The pulse lasts exactly the one cycle after the write. Bits [23:20] have no effect.
- R5: The reset byte (bits [23:16] of word 0x088) always reads as zero.
- R6: Bits [27:24] of word 0x088 are the sleep enables for channels 0 to 3. They are readable and writable and drive the sleep outputs. Bits [31:28] read as zero.
- R7: Word 0x08C reads 0x00002402: revision 0x02 in bits [7:0] and identification 0x24 in bits [15:8]. Writes to it have no effect.
- R8: In word 0x084, bits [7:0] are the timer control byte, bits [23:16] are the preload low byte and bits [31:24] are the preload high byte. All three are readable and writable and drive the timer ports. Bits [15:8] read as zero.
- R9: A write changes only the byte lanes whose byte enable is set. Byte enable k covers data bits [8k+7:8k].
- R10: Bits [7:0] of word 0x088 are the clock-mode byte. It is readable and writable and drives the clock-mode output. Bits [15:8] read as zero.
- R11: A read request raises the read-valid output in the next cycle, together with the read data. A write request does not raise read-valid. Word addresses outside 0x080 to 0x08C, including word 0x090, read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Single-cycle access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_word | input | 10 | Word address, byte address bits [11:2] |
| req_be | input | 4 | Byte enables for the write lanes |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| chan_irq | input | 4 | Interrupt line from each channel |
| io_irq | input | 1 | I/O interrupt input |
| irq_out | output | 1 | Combined interrupt |
| chan_reset | output | 4 | One-cycle soft-reset pulse for each channel |
| chan_sleep | output | 4 | Sleep enable for each channel |
| mode8x | output | 8 | Clock-mode byte |
| timer_ctrl | output | 8 | Timer control byte |
| timer_preload | output | 16 | Timer preload word |

## Verification
A single double-word write to word 0x088 can set the clock-mode byte, fire reset pulses and change the sleep enables in the same clock cycle. A read of the interrupt word can also coincide with a change on the channel interrupt lines and on the combined interrupt output. The bench provokes the first case with directed all-lane writes and with random byte-enable masks on that word. It provokes the second by changing the interrupt inputs in every request cycle. After each request the bench compares the pulse pattern, the sleep outputs, the combined interrupt and any read data with a model of the register state. The expected read data is taken from the interrupt inputs of the request cycle.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

  localparam int unsigned NUM_WORDS = 5;

  typedef enum logic [2:0] {
    W_IRQ = 3'd0,
    W_TMR = 3'd1,
    W_AUX = 3'd2,
    W_ID  = 3'd3,
    W_IO  = 3'd4
  } word_e;

  typedef struct packed {
    logic [7:0] tmsb;
    logic [7:0] tlsb;
    logic [7:0] tctl;
    logic [7:0] x8;
  } ctl_state_t;

endpackage

// File: rtl/devctl_decode.sv
module devctl_decode #(
  parameter int unsigned          WADDR_W   = 10,
  parameter int unsigned          NWORDS    = 5,
  parameter logic [WADDR_W-1:0]   BASE_WORD = 10'h020
) (
  input  logic [WADDR_W-1:0] word,
  output logic [NWORDS-1:0]  sel,
  output logic               hit
);

  for (genvar k = 0; k < NWORDS; k++) begin : g_sel
    assign sel[k] = (word == (BASE_WORD + WADDR_W'(k)));
  end

  assign hit = |sel;

endmodule

// File: rtl/devctl_store.sv
module devctl_store
  import devctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tmr,
  input  logic              wr_aux,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output ctl_state_t        st,
  output logic [NUM_CH-1:0] sleep
);

  ctl_state_t        st_q, st_d;
  logic [NUM_CH-1:0] sleep_q, sleep_d;
  logic              upd;
  logic              unused_bits;

  assign unused_bits = be[1] ^ (^wdata[15:8]);
  assign upd = wr_tmr | wr_aux;

  always_comb begin
    st_d    = st_q;
    sleep_d = sleep_q;
    if (wr_tmr) begin
      if (be[0]) st_d.tctl = wdata[7:0];
      if (be[2]) st_d.tlsb = wdata[23:16];
      if (be[3]) st_d.tmsb = wdata[31:24];
    end
    if (wr_aux) begin
      if (be[0]) st_d.x8  = wdata[7:0];
      if (be[3]) sleep_d  = wdata[24 +: NUM_CH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      sleep_q <= '0;
    end else if (upd) begin
      st_q    <= st_d;
      sleep_q <= sleep_d;
    end
  end

  assign st    = st_q;
  assign sleep = sleep_q;

  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_aux && be[3]) |-> $stable(sleep_q));

  // R9
  tmr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_tmr && be[2]) |-> $stable(st_q.tlsb));

endmodule

// File: rtl/devctl_pulse.sv
module devctl_pulse #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [NUM_CH-1:0] bits,
  output logic [NUM_CH-1:0] pulse
);

  logic [NUM_CH-1:0] pulse_q, pulse_d;

  always_comb begin
    pulse_d = '0;
    if (fire) pulse_d = bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;

  // R4
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) |-> $past(fire));

endmodule

// File: rtl/devctl_irq.sv
module devctl_irq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_irq,
  input  logic              io_irq,
  output logic [7:0]        status,
  output logic              irq_out
);

  logic any_d, any_q;

  assign status = 8'(chan_irq);
  assign any_d  = (|chan_irq) | io_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= any_d;
  end

  assign irq_out = any_q;

  // R3
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_out == ($past(|chan_irq) || $past(io_irq))));

endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
  import devctl_pkg::*;
#(
  parameter int unsigned        NUM_CH    = 4,
  parameter int unsigned        WADDR_W   = 10,
  parameter logic [WADDR_W-1:0] BASE_WORD = 10'h020,
  parameter logic [7:0]         REV_ID    = 8'h02,
  parameter logic [7:0]         DEV_ID    = 8'h24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [WADDR_W-1:0] req_word,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  input  logic [NUM_CH-1:0]  chan_irq,
  input  logic               io_irq,
  output logic               irq_out,
  output logic [NUM_CH-1:0]  chan_reset,
  output logic [NUM_CH-1:0]  chan_sleep,
  output logic [7:0]         mode8x,
  output logic [7:0]         timer_ctrl,
  output logic [15:0]        timer_preload
);

  localparam int unsigned NW = NUM_WORDS;

  logic [1:0]        rsync_q;
  logic              rst_core_n;
  logic [NW-1:0]     sel;
  logic              hit;
  logic              wr_en, rd_fire;
  ctl_state_t        st;
  logic [NUM_CH-1:0] sleep_q;
  logic [7:0]        irq_status;
  logic [31:0]       rd_d, rd_q;
  logic              rv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign wr_en   = req_valid & req_write;
  assign rd_fire = req_valid & ~req_write;

  devctl_decode #(
    .WADDR_W  (WADDR_W),
    .NWORDS   (NW),
    .BASE_WORD(BASE_WORD)
  ) u_decode (
    .word(req_word),
    .sel (sel),
    .hit (hit)
  );

  devctl_store #(.NUM_CH(NUM_CH)) u_store (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_tmr(wr_en & sel[W_TMR]),
    .wr_aux(wr_en & sel[W_AUX]),
    .be    (req_be),
    .wdata (req_wdata),
    .st    (st),
    .sleep (sleep_q)
  );

  devctl_pulse #(.NUM_CH(NUM_CH)) u_pulse (
    .clk  (clk),
    .rst_n(rst_core_n),
    .fire (wr_en & sel[W_AUX] & req_be[2]),
    .bits (req_wdata[16 +: NUM_CH]),
    .pulse(chan_reset)
  );

  devctl_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .chan_irq(chan_irq),
    .io_irq  (io_irq),
    .status  (irq_status),
    .irq_out (irq_out)
  );

  always_comb begin
    rd_d = '0;
    if (sel[W_IRQ]) rd_d = {24'h0, irq_status};
    if (sel[W_TMR]) rd_d = {st.tmsb, st.tlsb, 8'h00, st.tctl};
    if (sel[W_AUX]) rd_d = {8'(sleep_q), 16'h0000, st.x8};
    if (sel[W_ID])  rd_d = {16'h0000, DEV_ID, REV_ID};
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rv_q <= 1'b0;
    else             rv_q <= rd_fire;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rd_q <= '0;
    else if (rd_fire) rd_q <= rd_d;
  end

  assign rd_valid      = rv_q;
  assign rd_data       = rd_q;
  assign chan_sleep    = sleep_q;
  assign mode8x        = st.x8;
  assign timer_ctrl    = st.tctl;
  assign timer_preload = {st.tmsb, st.tlsb};

  // R11
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_valid |-> $past(req_valid && !req_write));

  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_valid && $past(!hit)) |-> (rd_data == 32'h0));

  // R7
  id_word_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_valid && $past(sel[W_ID])) |-> (rd_data == {16'h0000, DEV_ID, REV_ID}));

  // R2
  irq_word_upper_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_valid && $past(sel[W_IRQ])) |-> (rd_data[31:8] == 24'h0));

  // R5
  rst_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_valid && $past(sel[W_AUX])) |-> (rd_data[23:8] == 16'h0));

endmodule

// File: tb/devctl_regs_tb.sv
`timescale 1ns/1ps
module devctl_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [9:0]  req_word = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  chan_irq = '0;
  logic        io_irq = 1'b0;
  logic        irq_out;
  logic [3:0]  chan_reset;
  logic [3:0]  chan_sleep;
  logic [7:0]  mode8x;
  logic [7:0]  timer_ctrl;
  logic [15:0] timer_preload;

  always #2.5 clk = ~clk;

  devctl_regs u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .chan_irq(chan_irq), .io_irq(io_irq), .irq_out(irq_out),
    .chan_reset(chan_reset), .chan_sleep(chan_sleep), .mode8x(mode8x),
    .timer_ctrl(timer_ctrl), .timer_preload(timer_preload)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_tctl, m_tlsb, m_tmsb, m_x8;
  logic [3:0] m_sleep;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [9:0] w, input logic [3:0] irq);
    case (w)
      10'h020: return {28'h0, irq};
      10'h021: return {m_tmsb, m_tlsb, 8'h00, m_tctl};
      10'h022: return {4'h0, m_sleep, 16'h0000, m_x8};
      10'h023: return 32'h0000_2402;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [9:0] w);
    case (w)
      10'h020: return "R2 irq word";
      10'h021: return "R8 timer word";
      10'h022: return "R5 R6 R10 aux word";
      10'h023: return "R7 id word";
      default: return "R11 unmapped word";
    endcase
  endfunction

  task automatic check_outputs();
    chk("R6 sleep out", {28'h0, chan_sleep}, {28'h0, m_sleep});
    chk("R10 mode out", {24'h0, mode8x}, {24'h0, m_x8});
    chk("R8 timer out", {8'h0, timer_ctrl, timer_preload}, {8'h0, m_tctl, m_tmsb, m_tlsb});
  endtask

  // one request cycle; inputs driven at a falling edge, results checked at the next
  task automatic op(input bit we, input logic [9:0] w, input logic [3:0] be,
                    input logic [31:0] wd, input logic [3:0] irq, input bit io);
    logic [31:0] exp_rd;
    logic [3:0]  exp_pulse;
    req_valid = 1'b1; req_write = we; req_word = w; req_be = be; req_wdata = wd;
    chan_irq = irq; io_irq = io;
    exp_rd = exp_read(w, irq);
    exp_pulse = (we && w == 10'h022 && be[2]) ? wd[19:16] : 4'h0;
    if (we && w == 10'h021) begin
      if (be[0]) m_tctl = wd[7:0];
      if (be[2]) m_tlsb = wd[23:16];
      if (be[3]) m_tmsb = wd[31:24];
    end
    if (we && w == 10'h022) begin
      if (be[0]) m_x8 = wd[7:0];
      if (be[3]) m_sleep = wd[27:24];
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (!we) begin
      chk("R11 read valid", {31'h0, rd_valid}, 32'h1);
      chk(tag_of(w), rd_data, exp_rd);
    end else begin
      chk("R11 no valid on write", {31'h0, rd_valid}, 32'h0);
    end
    chk("R4 reset pulse", {28'h0, chan_reset}, {28'h0, exp_pulse});
    chk("R3 irq out", {31'h0, irq_out}, {31'h0, (|irq) | io});
    check_outputs();
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R4 pulse one cycle", {28'h0, chan_reset}, 32'h0);
    chk("R11 idle valid", {31'h0, rd_valid}, 32'h0);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  localparam logic [9:0] WLIST [8] = '{10'h020, 10'h021, 10'h022, 10'h023,
                                       10'h024, 10'h000, 10'h025, 10'h3FF};

  initial begin
    void'($urandom(32'h5EED_0154));
    m_tctl = '0; m_tlsb = '0; m_tmsb = '0; m_x8 = '0; m_sleep = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 reset pulse", {28'h0, chan_reset}, 32'h0);
    chk("R1 reset irq", {31'h0, irq_out}, 32'h0);
    check_outputs();
    for (int i = 0; i < 5; i++) op(1'b0, 10'h020 + 10'(i), 4'h0, 32'h0, 4'h0, 1'b0);

    // R4 R6 R10 all lanes of the aux word in one cycle
    op(1'b1, 10'h022, 4'hF, 32'hFFFF_FFFF, 4'h0, 1'b0);
    idle();
    op(1'b0, 10'h022, 4'h0, 32'h0, 4'h0, 1'b0);
    // R4 only the upper nibble of the reset byte: no pulse
    op(1'b1, 10'h022, 4'h4, 32'h00F0_0000, 4'h0, 1'b0);
    // R4 single channel, back to back
    op(1'b1, 10'h022, 4'h4, 32'h0004_0000, 4'h0, 1'b0);
    op(1'b1, 10'h022, 4'h4, 32'h0001_0000, 4'h0, 1'b0);
    idle();
    // R9 one lane of the timer word
    op(1'b1, 10'h021, 4'h4, 32'hAABB_CCDD, 4'h0, 1'b0);
    op(1'b0, 10'h021, 4'h0, 32'h0, 4'h0, 1'b0);
    // R7 write to id word ignored
    op(1'b1, 10'h023, 4'hF, 32'h1234_5678, 4'h0, 1'b0);
    op(1'b0, 10'h023, 4'h0, 32'h0, 4'h0, 1'b0);
    // R2 write to irq word ignored, read with lines active
    op(1'b1, 10'h020, 4'hF, 32'hFFFF_FFFF, 4'hA, 1'b0);
    op(1'b0, 10'h020, 4'h0, 32'h0, 4'h5, 1'b0);
    // R3 only the I/O interrupt
    op(1'b0, 10'h020, 4'h0, 32'h0, 4'h0, 1'b1);
    // R11 write to unmapped word 0x090 ignored
    op(1'b1, 10'h024, 4'hF, 32'hFFFF_FFFF, 4'h0, 1'b0);
    op(1'b0, 10'h024, 4'h0, 32'h0, 4'h0, 1'b0);

    for (int n = 0; n < 800; n++) begin
      logic [9:0] w;
      w = WLIST[$urandom_range(7, 0)];
      op(1'($urandom_range(1, 0)), w, 4'($urandom), $urandom, 4'($urandom),
         ($urandom_range(7, 0) == 0));
      if ($urandom_range(5, 0) == 0) idle();
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule